// File: doc/BRIEF.md
# Serial Channel FIFO Pair with Control and Receive Trigger

This block sits between the host bus and the shift paths of one asynchronous serial channel. It keeps a receive queue and a transmit queue, each 16 bytes deep. The receive shift path pushes bytes into the receive queue and the host pops them. The host pushes bytes into the transmit queue and the transmit shift path pops them. A write-only control byte enables the queues, clears either queue on its own, selects how the two active-low ready strobes behave, and picks the receive threshold that raises the data-available interrupt.

A control write is captured on the clock edge where `ctl_we_i` is high. Only a write with bit 0 set loads the mode and trigger fields and can request a clear. The clear requests are pulses and are not stored. When the queues are disabled, each queue holds a single byte and the receive threshold is one.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After reset the queues are disabled, both levels read 0, both overrun flags are 0, `rx_irq_o` is 0, `rx_rdy_no` is 1 and `tx_rdy_no` is 0. The mode is normal and the trigger code is 00.
- R2: A control write with bit 0 = 0 disables the queues. It ignores bits 1, 2, 3, 6 and 7: it clears nothing and leaves the stored mode and trigger unchanged.
- R3: A control write with bits 0 and 1 both 1 sets the receive level and the receive overrun flag to 0 at that edge. The request is not stored, so a later write with bit 1 = 0 clears nothing.
- R4: A control write with bits 0 and 2 both 1 sets the transmit level and the transmit overrun flag to 0 at that edge. The receive queue is left alone.
- R5: Bits 4 and 5 of the control byte have no effect.
- R6: When enabled, bits 7:6 select the receive threshold: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14. `rx_irq_o` is 1 exactly while the receive level is at or above the threshold. When disabled, the threshold is 1.
- R7: Bit 3 = 0 selects normal mode. In this mode `rx_rdy_no` is low while the receive level is at least 1, and `tx_rdy_no` is low only while the transmit level is 0.
- R8: Bit 3 = 1 selects DMA mode. In this mode `rx_rdy_no` is low while the receive level is at or above the threshold or while `rx_timeout_i` is 1, and `tx_rdy_no` is low while the transmit queue is not full.
- R9: The queue capacity is 16 bytes when enabled and 1 byte when disabled. A push into a full queue is dropped and sets that queue's overrun flag. The flag stays set until that queue is cleared.
- R10: Bytes leave each queue in the order they entered. A pop places the head byte on the data output after that edge. A pop from an empty queue leaves the data output and the level unchanged.
- R11: A control write that changes the enable state clears both queues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_we_i | input | 1 | Control byte write strobe |
| ctl_wdata_i | input | 8 | Control byte |
| rx_push_i | input | 1 | Receive shift path delivers a byte |
| rx_data_i | input | 8 | Byte from the receive shift path |
| rx_pop_i | input | 1 | Host reads a receive byte |
| rx_data_o | output | 8 | Last byte popped from the receive queue |
| rx_level_o | output | 5 | Receive queue occupancy |
| rx_overrun_o | output | 1 | Sticky: a receive push was dropped |
| tx_push_i | input | 1 | Host writes a transmit byte |
| tx_data_i | input | 8 | Transmit byte from the host |
| tx_pop_i | input | 1 | Transmit shift path takes a byte |
| tx_data_o | output | 8 | Last byte popped from the transmit queue |
| tx_level_o | output | 5 | Transmit queue occupancy |
| tx_overrun_o | output | 1 | Sticky: a transmit push was dropped |
| rx_timeout_i | input | 1 | Receive timeout indication |
| rx_irq_o | output | 1 | Receive data available interrupt |
| rx_rdy_no | output | 1 | Receive ready strobe, active low |
| tx_rdy_no | output | 1 | Transmit ready strobe, active low |

## Verification
Levels, overrun flags, popped data and the effects of control writes are all registered, so each of them is due on the first clock edge after the stimulus. The interrupt and the ready strobes decode registered state without further delay, so they follow that same edge. The one exception is `rx_timeout_i`, which reaches `rx_rdy_no` with no clock in between. The bench drives inputs shortly after a rising edge and samples 2 ns after the next rising edge. For the timeout path it samples after a 1 ns settle, with no clock edge in between.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
  localparam int unsigned CTL_EN     = 0;
  localparam int unsigned CTL_RX_CLR = 1;
  localparam int unsigned CTL_TX_CLR = 2;
  localparam int unsigned CTL_DMA    = 3;
  localparam int unsigned CTL_TRIG   = 6;

  typedef enum logic [1:0] {
    TRIG_1  = 2'b00,
    TRIG_4  = 2'b01,
    TRIG_8  = 2'b10,
    TRIG_14 = 2'b11
  } rx_trig_e;

  typedef struct packed {
    logic     en;
    logic     dma;
    rx_trig_e trig;
  } fifo_cfg_t;

  function automatic int unsigned trig_count(rx_trig_e t);
    case (t)
      TRIG_4:  return 4;
      TRIG_8:  return 8;
      TRIG_14: return 14;
      default: return 1;
    endcase
  endfunction
endpackage

// File: rtl/uart_fifo_ctl_reg.sv
module uart_fifo_ctl_reg
  import uart_fifo_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output fifo_cfg_t  cfg_o,
  output logic       rx_clr_o,
  output logic       tx_clr_o
);
  fifo_cfg_t cfg_q;
  logic      armed;
  logic      en_flip;

  assign armed   = we_i & wdata_i[CTL_EN];
  assign en_flip = we_i & (wdata_i[CTL_EN] != cfg_q.en);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '{en: 1'b0, dma: 1'b0, trig: TRIG_1};
    end else if (armed) begin
      cfg_q.en   <= 1'b1;
      cfg_q.dma  <= wdata_i[CTL_DMA];
      cfg_q.trig <= rx_trig_e'(wdata_i[CTL_TRIG +: 2]);
    end else if (we_i) begin
      cfg_q.en <= 1'b0;
    end
  end

  // clear requests are pulses, never stored
  assign rx_clr_o = (armed & wdata_i[CTL_RX_CLR]) | en_flip;
  assign tx_clr_o = (armed & wdata_i[CTL_TX_CLR]) | en_flip;
  assign cfg_o    = cfg_q;
endmodule

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
  parameter  int unsigned DW    = 8,
  parameter  int unsigned DEPTH = 16,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [LW-1:0] cap_i,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic [LW-1:0] level_o,
  output logic          full_o,
  output logic          overrun_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [LW-1:0] level_q;
  logic [DW-1:0] rdata_q;
  logic          ovr_q;
  logic          full, do_push, do_pop;

  function automatic logic [AW-1:0] ptr_next(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = level_q >= cap_i;
  assign do_push = push_i & ~full;
  assign do_pop  = pop_i & (level_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
      rdata_q  <= '0;
      ovr_q    <= 1'b0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
      ovr_q    <= 1'b0;
    end else begin
      if (do_push) wr_ptr_q <= ptr_next(wr_ptr_q);
      if (do_pop) begin
        rd_ptr_q <= ptr_next(rd_ptr_q);
        rdata_q  <= mem_q[rd_ptr_q];
      end
      case ({do_push, do_pop})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
      if (push_i && full) ovr_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!clr_i && do_push) mem_q[wr_ptr_q] <= wdata_i;
  end

  assign rdata_o   = rdata_q;
  assign level_o   = level_q;
  assign full_o    = full;
  assign overrun_o = ovr_q;
endmodule

// File: rtl/uart_fifo_trig.sv
module uart_fifo_trig
  import uart_fifo_pkg::*;
#(
  parameter  int unsigned DEPTH = 16,
  localparam int unsigned LW    = $clog2(DEPTH + 1)
) (
  input  fifo_cfg_t     cfg_i,
  input  logic [LW-1:0] rx_level_i,
  input  logic [LW-1:0] tx_level_i,
  input  logic          tx_full_i,
  input  logic          rx_timeout_i,
  output logic          rx_irq_o,
  output logic          rx_rdy_no,
  output logic          tx_rdy_no
);
  logic [LW-1:0] thr;
  logic          rx_hit;

  assign thr    = cfg_i.en ? LW'(trig_count(cfg_i.trig)) : LW'(1);
  assign rx_hit = rx_level_i >= thr;

  assign rx_irq_o  = rx_hit;
  assign rx_rdy_no = cfg_i.dma ? ~(rx_hit | rx_timeout_i) : (rx_level_i == '0);
  assign tx_rdy_no = cfg_i.dma ? tx_full_i : (tx_level_i != '0);
endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
  import uart_fifo_pkg::*;
#(
  parameter  int unsigned DW    = 8,
  parameter  int unsigned DEPTH = 16,
  localparam int unsigned LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctl_we_i,
  input  logic [7:0]    ctl_wdata_i,
  input  logic          rx_push_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          rx_pop_i,
  output logic [DW-1:0] rx_data_o,
  output logic [LW-1:0] rx_level_o,
  output logic          rx_overrun_o,
  input  logic          tx_push_i,
  input  logic [DW-1:0] tx_data_i,
  input  logic          tx_pop_i,
  output logic [DW-1:0] tx_data_o,
  output logic [LW-1:0] tx_level_o,
  output logic          tx_overrun_o,
  input  logic          rx_timeout_i,
  output logic          rx_irq_o,
  output logic          rx_rdy_no,
  output logic          tx_rdy_no
);
  fifo_cfg_t     cfg;
  logic          rx_clr, tx_clr;
  logic [LW-1:0] cap;
  logic          rx_full, tx_full;

  // single-byte holding mode while disabled
  assign cap = cfg.en ? LW'(DEPTH) : LW'(1);

  uart_fifo_ctl_reg u_ctl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (ctl_we_i),
    .wdata_i  (ctl_wdata_i),
    .cfg_o    (cfg),
    .rx_clr_o (rx_clr),
    .tx_clr_o (tx_clr)
  );

  uart_byte_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rx_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (rx_clr),
    .cap_i     (cap),
    .push_i    (rx_push_i),
    .wdata_i   (rx_data_i),
    .pop_i     (rx_pop_i),
    .rdata_o   (rx_data_o),
    .level_o   (rx_level_o),
    .full_o    (rx_full),
    .overrun_o (rx_overrun_o)
  );

  uart_byte_fifo #(.DW(DW), .DEPTH(DEPTH)) u_tx_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (tx_clr),
    .cap_i     (cap),
    .push_i    (tx_push_i),
    .wdata_i   (tx_data_i),
    .pop_i     (tx_pop_i),
    .rdata_o   (tx_data_o),
    .level_o   (tx_level_o),
    .full_o    (tx_full),
    .overrun_o (tx_overrun_o)
  );

  uart_fifo_trig #(.DEPTH(DEPTH)) u_trig (
    .cfg_i        (cfg),
    .rx_level_i   (rx_level_o),
    .tx_level_i   (tx_level_o),
    .tx_full_i    (tx_full),
    .rx_timeout_i (rx_timeout_i),
    .rx_irq_o     (rx_irq_o),
    .rx_rdy_no    (rx_rdy_no),
    .tx_rdy_no    (tx_rdy_no)
  );

  logic unused_rx_full;
  assign unused_rx_full = rx_full;
endmodule

// File: rtl/uart_fifo_ctrl_chk.sv
module uart_fifo_ctrl_chk #(
  parameter  int unsigned DW    = 8,
  parameter  int unsigned DEPTH = 16,
  localparam int unsigned LW    = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ctl_we_i,
  input logic [7:0]    ctl_wdata_i,
  input logic          rx_push_i,
  input logic          rx_pop_i,
  input logic [DW-1:0] rx_data_o,
  input logic [LW-1:0] rx_level_o,
  input logic          rx_overrun_o,
  input logic [LW-1:0] tx_level_o,
  input logic          rx_irq_o,
  input logic          fifo_en_i
);
  localparam logic [LW-1:0] LVL_MAX = LW'(DEPTH);

  AST_LEVEL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_level_o <= LVL_MAX && tx_level_o <= LVL_MAX); // R9

  AST_RX_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_i && ctl_wdata_i[0] && ctl_wdata_i[1] |=> rx_level_o == '0); // R3

  AST_TX_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_i && ctl_wdata_i[0] && ctl_wdata_i[2] |=> tx_level_o == '0); // R4

  AST_OFF_WRITE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_i && !ctl_wdata_i[0] && !fifo_en_i && !rx_push_i && !rx_pop_i
    |=> $stable(rx_level_o)); // R2

  AST_EMPTY_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pop_i && rx_level_o == '0 && !rx_push_i && !ctl_we_i
    |=> $stable(rx_data_o) && rx_level_o == '0); // R10

  AST_OVERRUN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_i && !rx_pop_i && !ctl_we_i && fifo_en_i && rx_level_o == LVL_MAX
    |=> rx_overrun_o && rx_level_o == LVL_MAX); // R9

  AST_IRQ_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_o |-> rx_level_o != '0); // R6
endmodule

bind uart_fifo_ctrl uart_fifo_ctrl_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ctl_we_i     (ctl_we_i),
  .ctl_wdata_i  (ctl_wdata_i),
  .rx_push_i    (rx_push_i),
  .rx_pop_i     (rx_pop_i),
  .rx_data_o    (rx_data_o),
  .rx_level_o   (rx_level_o),
  .rx_overrun_o (rx_overrun_o),
  .tx_level_o   (tx_level_o),
  .rx_irq_o     (rx_irq_o),
  .fifo_en_i    (cfg.en)
);

// File: tb/uart_fifo_ctrl_tb.sv
module uart_fifo_ctrl_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ctl_we_i = 1'b0;
  logic [7:0] ctl_wdata_i = '0;
  logic       rx_push_i = 1'b0, rx_pop_i = 1'b0;
  logic [7:0] rx_data_i = '0, rx_data_o;
  logic [4:0] rx_level_o, tx_level_o;
  logic       rx_overrun_o, tx_overrun_o;
  logic       tx_push_i = 1'b0, tx_pop_i = 1'b0;
  logic [7:0] tx_data_i = '0, tx_data_o;
  logic       rx_timeout_i = 1'b0;
  logic       rx_irq_o, rx_rdy_no, tx_rdy_no;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  uart_fifo_ctrl u_dut (.*);

  // {we, ctl byte, pushes, pops, exp rx level, exp irq, exp rx_rdy_no}
  localparam int NV = 14;
  localparam logic [25:0] VEC [NV] = '{
    {1'b1, 8'h01, 5'd1,  5'd0, 5'd1,  1'b1, 1'b0},  // R6 trig 1, R11 enable
    {1'b1, 8'h43, 5'd3,  5'd0, 5'd3,  1'b0, 1'b0},  // R3 clear, R6 trig 4
    {1'b0, 8'h00, 5'd1,  5'd0, 5'd4,  1'b1, 1'b0},  // R6 reach 4
    {1'b1, 8'h83, 5'd7,  5'd0, 5'd7,  1'b0, 1'b0},  // R6 trig 8
    {1'b0, 8'h00, 5'd1,  5'd0, 5'd8,  1'b1, 1'b0},
    {1'b0, 8'h00, 5'd0,  5'd1, 5'd7,  1'b0, 1'b0},  // R6 falls below
    {1'b1, 8'hC3, 5'd14, 5'd0, 5'd14, 1'b1, 1'b0},  // R6 trig 14
    {1'b0, 8'h00, 5'd0,  5'd1, 5'd13, 1'b0, 1'b0},
    {1'b1, 8'hCB, 5'd13, 5'd0, 5'd13, 1'b0, 1'b1},  // R8 dma below trig
    {1'b0, 8'h00, 5'd1,  5'd0, 5'd14, 1'b1, 1'b0},  // R8 dma at trig
    {1'b1, 8'h30, 5'd3,  5'd0, 5'd1,  1'b1, 1'b0},  // R11 disable clears, R9 cap 1
    {1'b1, 8'hF6, 5'd0,  5'd0, 5'd1,  1'b1, 1'b0},  // R2 no clear while off
    {1'b1, 8'h01, 5'd2,  5'd0, 5'd2,  1'b1, 1'b0},  // R11 enable clears
    {1'b1, 8'hC9, 5'd0,  5'd0, 5'd2,  1'b0, 1'b1}   // R8 load without clear
  };

  task automatic tick();
    @(posedge clk_i);
    #2;
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_ctl(logic [7:0] d);
    ctl_we_i = 1'b1; ctl_wdata_i = d;
    tick();
    ctl_we_i = 1'b0;
  endtask

  task automatic rx_put(int n, logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      rx_push_i = 1'b1; rx_data_i = base + 8'(i);
      tick();
    end
    rx_push_i = 1'b0;
  endtask

  task automatic rx_take(int n);
    for (int i = 0; i < n; i++) begin
      rx_pop_i = 1'b1;
      tick();
    end
    rx_pop_i = 1'b0;
  endtask

  task automatic tx_put(int n, logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      tx_push_i = 1'b1; tx_data_i = base + 8'(i);
      tick();
    end
    tx_push_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, got 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #35 rst_ni = 1'b1;
    tick();
    // R1 reset state
    chk("R1 rx level", rx_level_o, 0);
    chk("R1 tx level", tx_level_o, 0);
    chk("R1 irq", rx_irq_o, 0);
    chk("R1 rx_rdy_no", rx_rdy_no, 1);
    chk("R1 tx_rdy_no", tx_rdy_no, 0);
    chk("R1 overrun", {rx_overrun_o, tx_overrun_o}, 0);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][25]) wr_ctl(VEC[v][24:17]);
      rx_put(int'(VEC[v][16:12]), 8'h10);
      rx_take(int'(VEC[v][11:7]));
      chk($sformatf("R6 vec%0d level", v), rx_level_o, int'(VEC[v][6:2]));
      chk($sformatf("R6 vec%0d irq", v), rx_irq_o, int'(VEC[v][1]));
      chk($sformatf("R8 vec%0d rx_rdy_no", v), rx_rdy_no, int'(VEC[v][0]));
    end

    // R2: dma bit kept across writes with bit0 = 0
    wr_ctl(8'h00);
    chk("R11 disable clears", rx_level_o, 0);
    rx_timeout_i = 1'b1; #1;
    chk("R2 dma kept", rx_rdy_no, 0);
    rx_timeout_i = 1'b0;
    wr_ctl(8'hF6);
    rx_timeout_i = 1'b1; #1;
    chk("R2 bit3 ignored", rx_rdy_no, 0);
    rx_timeout_i = 1'b0; #1;
    chk("R8 no timeout", rx_rdy_no, 1);

    // R5 reserved bits, R3 self-clearing request
    wr_ctl(8'h01);
    rx_put(2, 8'hA0);
    wr_ctl(8'h31);
    chk("R5 reserved no clear", rx_level_o, 2);
    wr_ctl(8'h01);
    chk("R3 not retained", rx_level_o, 2);

    // R10 order and empty pop
    rx_take(1);
    chk("R10 first byte", rx_data_o, 8'hA0);
    rx_take(1);
    chk("R10 second byte", rx_data_o, 8'hA1);
    rx_take(1);
    chk("R10 empty pop data", rx_data_o, 8'hA1);
    chk("R10 empty pop level", rx_level_o, 0);

    // R7 normal tx ready, R4 tx clear
    chk("R7 tx empty ready", tx_rdy_no, 0);
    tx_put(1, 8'h55);
    chk("R7 tx busy", tx_rdy_no, 1);
    tx_pop_i = 1'b1; tick(); tx_pop_i = 1'b0;
    chk("R10 tx data", tx_data_o, 8'h55);
    chk("R7 tx ready again", tx_rdy_no, 0);
    rx_put(1, 8'h77);
    tx_put(3, 8'h60);
    wr_ctl(8'h05);
    chk("R4 tx cleared", tx_level_o, 0);
    chk("R4 rx untouched", rx_level_o, 1);

    // R8 dma tx ready, R9 tx overrun
    wr_ctl(8'h09);
    tx_put(15, 8'h00);
    chk("R8 tx below full", tx_rdy_no, 0);
    tx_put(1, 8'h0F);
    chk("R8 tx full", tx_rdy_no, 1);
    chk("R9 no overrun yet", tx_overrun_o, 0);
    tx_put(1, 8'hEE);
    chk("R9 tx level capped", tx_level_o, 16);
    chk("R9 tx overrun", tx_overrun_o, 1);
    wr_ctl(8'h0D);
    chk("R4 overrun cleared", tx_overrun_o, 0);
    chk("R8 tx ready after clear", tx_rdy_no, 0);

    // R8 timeout in dma mode
    wr_ctl(8'h4B);
    chk("R3 rx cleared", rx_level_o, 0);
    chk("R8 idle rx_rdy_no", rx_rdy_no, 1);
    rx_timeout_i = 1'b1; #1;
    chk("R8 timeout ready", rx_rdy_no, 0);
    rx_timeout_i = 1'b0;

    // R9 rx overrun
    rx_put(17, 8'h20);
    chk("R9 rx level capped", rx_level_o, 16);
    chk("R9 rx overrun", rx_overrun_o, 1);
    chk("R6 irq at 16", rx_irq_o, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule